// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Identifier Readout

This block is a clocked behavioural stand-in for a byte-wide, one-time-programmable memory. It can serve as a testbench target or replace the real part in an FPGA prototype. On every clock edge it samples an active-low chip select, an active-low output enable, a flag that says the programming supply is present, and a flag that says the high-voltage identifier level is on address bit 9. From these it chooses one of seven access modes. In read, program-verify and identifier modes it drives the data bus. In the other modes it releases the bus. The tri-state bus is modelled as a data output plus an output-enable.

Stored bits can only be cleared. A program pulse runs while chip select is low with the programming supply on and output enable high. When chip select is next seen high, the byte and address that were held during the pulse are ANDed into the array. The identifier mode returns a 7-bit manufacturer or device code chosen by address bit 0, with an odd-parity bit placed on data bit 7. An erase sequencer writes all-ones into every location, one location per clock. It runs after reset and again on request.

The depth is `2**ADDR_W`. The default of 10 keeps elaboration small, and 15 gives the full 32K x 8 array.

Top module: `otp_sig_mem`

## Requirements
- R1: With chip select low, output enable low and the identifier flag clear, the byte stored at `addr` appears on `dq_out` with `dq_oe` high one clock after the inputs are sampled. The programming flag has no effect here.
- R2: With chip select low, output enable high and no programming supply, `dq_oe` is low. Whenever `dq_oe` is low, `dq_out` reads 8'h00.
- R3: With chip select high and no programming supply, `dq_oe` is low whatever output enable does.
- R4: With the programming supply on, chip select low and output enable high, the bus is released. On the first clock where chip select is sampled high after such a pulse, the location at the address held in the pulse's last cycle becomes its old value AND the data held in that cycle.
- R5: With the programming supply on, chip select high and output enable low, the stored byte at `addr` is driven (program verify).
- R6: With the programming supply on and both chip select and output enable high, the bus is released and no location changes.
- R7: With the identifier flag set, chip select and output enable low, and every address bit above bit 0 low, the output is 8'h01 when `addr[0]`=0 and 8'h10 when `addr[0]`=1. Bit 7 holds odd parity over the byte.
- R8: In identifier mode with any address bit above bit 0 set, the output is 8'hFF and `id_err` is high. `id_err` is low in every other case.
- R9: After reset, and after an `erase_req` sampled while idle, `busy` stays high for exactly `2**ADDR_W` clock cycles. Every location then reads 8'hFF.
- R10: While `busy` is high, the bus is released, `id_err` is low, program pulses write nothing and `erase_req` is ignored.
- R11: Two program operations on one location leave the AND of both data bytes, so bits are never set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | High-voltage identifier level on address bit 9 |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data to program |
| erase_req | input | 1 | Start a whole-array erase |
| dq_out | output | 8 | Data driven onto the bus |
| dq_oe | output | 1 | Bus drive enable |
| id_err | output | 1 | Identifier requested with a non-zero upper address |
| busy | output | 1 | Erase in progress |

## Verification
Two functions can land on the same clock edge. One is the edge where chip select rises to end a program pulse. The other is the edge where an erase request is sampled. The bench drives both at once: the last program cycle is followed by a step that raises chip select and asserts `erase_req` together. It expects the AND-write to land and then be wiped by the erase, so the location reads 8'hFF once `busy` falls. A second case ends program pulses while an erase is running and checks that those locations still read all-ones afterwards.

// File: rtl/otp_sig_pkg.sv
package otp_sig_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STBY,
    MD_READ,
    MD_ODIS,
    MD_PROG,
    MD_PVFY,
    MD_PINH,
    MD_IDENT
  } acc_mode_e;

  function automatic logic mode_drives(acc_mode_e m);
    return (m == MD_READ) || (m == MD_PVFY) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_sig_pkg::*;
(
  input  logic      ce_n_i,
  input  logic      oe_n_i,
  input  logic      vpp_i,
  input  logic      hv_i,
  output acc_mode_e mode_o
);

  always_comb begin
    if (ce_n_i) begin
      if (vpp_i) mode_o = oe_n_i ? MD_PINH : MD_PVFY;
      else       mode_o = MD_STBY;
    end else if (!oe_n_i) begin
      mode_o = hv_i ? MD_IDENT : MD_READ;
    end else begin
      mode_o = vpp_i ? MD_PROG : MD_ODIS;
    end
  end

endmodule

// File: rtl/otp_sig_rom.sv
module otp_sig_rom
  import otp_sig_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter logic [6:0] MFR_ID7 = 7'h01,
  parameter logic [6:0] DEV_ID7 = 7'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BYTE_W-1:0] code_o,
  output logic              bad_o
);

  localparam logic [BYTE_W-1:0] MFR_BYTE = {~^MFR_ID7, MFR_ID7};
  localparam logic [BYTE_W-1:0] DEV_BYTE = {~^DEV_ID7, DEV_ID7};

  generate
    if (ADDR_W > 1) begin : g_wide
      assign bad_o = |addr_i[ADDR_W-1:1];
    end else begin : g_narrow
      assign bad_o = 1'b0;
    end
  endgenerate

  assign code_o = addr_i[0] ? DEV_BYTE : MFR_BYTE;

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_sig_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req_i,
  input  logic              pgm_we_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic [BYTE_W-1:0] pgm_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              busy_o
);

  localparam int                DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_val;
  logic [BYTE_W-1:0] old_byte;

  // erase sequencer next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end else if (erase_req_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // single write port: erase has priority, program clears bits only
  assign old_byte = mem[pgm_addr_i];

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = pgm_addr_i;
    wr_val  = old_byte & pgm_data_i;
    if (busy_q) begin
      wr_en   = 1'b1;
      wr_addr = cnt_q;
      wr_val  = '1;
    end else if (pgm_we_i) begin
      wr_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_val;
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = busy_q;

  // R11: a program write never sets a bit that was clear
  p_clear_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_we_i && !busy_q) |=> ((mem[$past(pgm_addr_i)] & ~$past(old_byte)) == '0))
    else $error("program write set a cleared bit");

  // R9: erase ends exactly at the last location
  p_erase_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> !busy_q)
    else $error("erase overran");

  p_erase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> busy_q)
    else $error("erase ended early");

endmodule

// File: rtl/otp_sig_mem.sv
module otp_sig_mem
  import otp_sig_pkg::*;
#(
  parameter int         ADDR_W  = 10,
  parameter logic [6:0] MFR_ID7 = 7'h01,
  parameter logic [6:0] DEV_ID7 = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  input  logic              erase_req,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              id_err,
  output logic              busy
);

  acc_mode_e         mode;
  logic [BYTE_W-1:0] id_code;
  logic              id_bad;
  logic [BYTE_W-1:0] rd_data;
  logic              busy_w;

  logic              prog_q, prog_d;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [BYTE_W-1:0] lat_data_q;
  logic              pgm_we;

  logic [BYTE_W-1:0] out_q, out_d;
  logic              oe_q, oe_d;
  logic              err_q, err_d;

  otp_mode_decode u_dec (
    .ce_n_i (ce_n),
    .oe_n_i (oe_n),
    .vpp_i  (vpp_on),
    .hv_i   (a9_hv),
    .mode_o (mode)
  );

  otp_sig_rom #(
    .ADDR_W  (ADDR_W),
    .MFR_ID7 (MFR_ID7),
    .DEV_ID7 (DEV_ID7)
  ) u_rom (
    .addr_i (addr),
    .code_o (id_code),
    .bad_o  (id_bad)
  );

  otp_cell_array #(
    .ADDR_W (ADDR_W)
  ) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase_req_i (erase_req),
    .pgm_we_i    (pgm_we),
    .pgm_addr_i  (lat_addr_q),
    .pgm_data_i  (lat_data_q),
    .rd_addr_i   (addr),
    .rd_data_o   (rd_data),
    .busy_o      (busy_w)
  );

  // program pulse tracking: the write lands when chip select is seen high
  assign prog_d = (mode == MD_PROG) && !busy_w;
  assign pgm_we = prog_q && ce_n && !busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
    end else begin
      prog_q <= prog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else if (prog_d) begin
      lat_addr_q <= addr;
      lat_data_q <= dq_in;
    end
  end

  // output stage next state
  always_comb begin
    oe_d  = !busy_w && mode_drives(mode);
    err_d = !busy_w && (mode == MD_IDENT) && id_bad;
    out_d = '0;
    if (oe_d) begin
      if (mode == MD_IDENT) out_d = id_bad ? '1 : id_code;
      else                  out_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      err_q <= err_d;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;
  assign id_err = err_q;
  assign busy   = busy_w;

  p_odis_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_on) |=> !dq_oe)
    else $error("bus driven with output enable high");

  p_hiz_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0))
    else $error("released bus carries data");

  p_stby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_on) |=> !dq_oe)
    else $error("bus driven in standby");

  p_inhibit_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && oe_n) |=> !dq_oe)
    else $error("bus driven in inhibit");

  p_id_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && !busy_w && !id_bad) |=> (dq_oe && ^dq_out))
    else $error("identifier byte lacks odd parity");

  p_id_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> (dq_oe && dq_out == 8'hFF))
    else $error("error flag without all-ones output");

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> (!dq_oe && !id_err))
    else $error("bus active during erase");

endmodule

// File: tb/otp_sig_mem_tb_top.sv
module otp_sig_mem_tb_top;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, vpp_on, a9_hv, erase_req;
  logic [AW-1:0] addr;
  logic [7:0]    dq_in;
  logic [7:0]    dq_out;
  logic          dq_oe, id_err, busy;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of the requirements
  logic [7:0]    m_mem [DEPTH];
  bit            m_busy;
  int            m_cnt;
  bit            m_pp;
  logic [AW-1:0] m_la;
  logic [7:0]    m_ld;

  always #10 clk = ~clk;

  otp_sig_mem #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .vpp_on    (vpp_on),
    .a9_hv     (a9_hv),
    .addr      (addr),
    .dq_in     (dq_in),
    .erase_req (erase_req),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .id_err    (id_err),
    .busy      (busy)
  );

  function automatic string auto_tag(bit b, bit ce, bit oe, bit vp, bit a9, logic [AW-1:0] a);
    if (b) return "R10";
    if (!ce && !oe) return a9 ? (((a >> 1) != 0) ? "R8" : "R7") : "R1";
    if (!ce) return vp ? "R4" : "R2";
    if (!vp) return "R3";
    return oe ? "R6" : "R5";
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe,out,err,busy} act=%h exp=%h", tag, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at the next falling edge
  task automatic step(bit ce, bit oe, bit vp, bit a9, logic [AW-1:0] a,
                      logic [7:0] d, bit er, string tag);
    bit          drv, bad, b0, e_err;
    logic [7:0]  e_out;
    string       t;
    ce_n = ce; oe_n = oe; vpp_on = vp; a9_hv = a9; addr = a; dq_in = d; erase_req = er;
    @(posedge clk);
    b0    = m_busy;
    bad   = ((a >> 1) != 0);
    drv   = !b0 && ((!ce && !oe) || (ce && !oe && vp));
    e_err = !b0 && !ce && !oe && a9 && bad;
    e_out = 8'h00;
    if (drv) begin
      if (!ce && !oe && a9) e_out = bad ? 8'hFF : (a[0] ? 8'h10 : 8'h01);
      else                  e_out = m_mem[a];
    end
    if (b0) begin
      m_mem[m_cnt] = 8'hFF;
      if (m_cnt == DEPTH - 1) m_busy = 0;
      m_cnt++;
    end else begin
      if (m_pp && ce) m_mem[m_la] = m_mem[m_la] & m_ld;
      if (er) begin m_busy = 1; m_cnt = 0; end
    end
    m_pp = !ce && oe && vp && !b0;
    if (m_pp) begin m_la = a; m_ld = d; end
    t = (tag == "") ? auto_tag(b0, ce, oe, vp, a9, a) : tag;
    @(negedge clk);
    check(t, {dq_oe, dq_out, id_err, busy}, {drv, e_out, e_err, m_busy});
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, '0, 8'h00, 0, tag);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d, string tag);
    step(0, 1, 1, 0, a, d, 0, tag);
    step(0, 1, 1, 0, a, d, 0, tag);
    step(1, 1, 1, 0, a, d, 0, tag);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    step(0, 0, 0, 0, a, 8'h00, 0, tag);
  endtask

  task automatic wait_erase(string tag);
    while (m_busy) step(1, 1, 0, 0, '0, 8'h00, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    m_busy = 1; m_cnt = 0; m_pp = 0; m_la = '0; m_ld = '0;
    rst_n = 0; ce_n = 1; oe_n = 1; vpp_on = 0; a9_hv = 0; addr = '0; dq_in = '0; erase_req = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {dq_oe, dq_out, id_err, busy}, {1'b0, 8'h00, 1'b0, 1'b1});
    rst_n = 1;
    // R9 / R10: power-up erase, with requests and reads during it ignored
    step(0, 0, 0, 0, 10'd5, 8'h00, 1, "R10");
    step(0, 1, 1, 0, 10'd8, 8'h00, 0, "R10");
    step(1, 1, 1, 0, 10'd8, 8'h00, 0, "R10");
    wait_erase("R9");
    rd(10'd8, "R10");
    rd(10'd5, "R1");
    // R4 / R11: program and re-program
    prog(10'd3, 8'h5A, "R4");
    rd(10'd3, "R4");
    prog(10'd3, 8'h0F, "R11");
    rd(10'd3, "R11");
    prog(10'd3, 8'hFF, "R11");
    rd(10'd3, "R11");
    // R6: inhibit pulses leave contents, checked through verify
    step(1, 1, 1, 0, 10'd3, 8'h00, 0, "R6");
    step(1, 1, 1, 0, 10'd3, 8'h00, 0, "R6");
    step(1, 0, 1, 0, 10'd3, 8'h00, 0, "R6");
    step(1, 0, 1, 0, 10'd4, 8'h00, 0, "R5");
    // R2 / R3
    step(0, 1, 0, 0, 10'd3, 8'h00, 0, "R2");
    step(1, 0, 0, 0, 10'd3, 8'h00, 0, "R3");
    step(1, 1, 0, 0, 10'd3, 8'h00, 0, "R3");
    // R7 / R8: identifier
    step(0, 0, 0, 1, 10'd0, 8'h00, 0, "R7");
    step(0, 0, 0, 1, 10'd1, 8'h00, 0, "R7");
    step(0, 0, 1, 1, 10'd1, 8'h00, 0, "R7");
    step(0, 0, 0, 1, 10'd2, 8'h00, 0, "R8");
    step(0, 0, 0, 1, 10'h200, 8'h00, 0, "R8");
    step(0, 0, 0, 1, 10'd0, 8'h00, 0, "R8");
    // collision: program pulse ends on the same edge as an erase request
    step(0, 1, 1, 0, 10'd7, 8'h00, 0, "R4");
    step(1, 1, 1, 0, 10'd7, 8'h00, 1, "R9");
    wait_erase("R9");
    rd(10'd7, "R9");
    rd(10'd3, "R9");
    // constrained random
    for (int i = 0; i < 600; i++) begin
      bit ce, oe, vp, a9;
      ce = $urandom_range(0, 1);
      oe = $urandom_range(0, 1);
      vp = $urandom_range(0, 1);
      a9 = ($urandom_range(0, 7) == 0);
      step(ce, oe, vp, a9, AW'($urandom_range(0, 15)), 8'($urandom), 0, "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule